// File: doc/BRIEF.md
# Word-Framed SPI Master With Register Port

This block is a memory-mapped SPI master that moves one word of 1 to 32 bits per launch. Software pushes the outgoing word into a small transmit queue, programs the frame length, clock polarity, clock phase and the transmit/receive enables in the command register, and sets the launch bit. The block then toggles the serial clock, drives the outgoing line, samples the incoming line and, when the frame ends, places the received word in a receive queue.

Completion is reported in a status register. Its event bits stay set until software writes ones to them. Writing back a status value just read clears every event it showed. Chip select is either driven by hardware for the length of a frame or set by software as a level, with inverted sense.

Register map (byte addresses): command 0x00, status 0x04, transmit queue write port 0x10, receive queue read port 0x20. Both queues are 4 words deep.

Top module: `spi_word_master`

## Requirements
- R1: After reset the command register reads 0, the status register reads 0x0280_0000 (only both queue-empty flags set), cs_no is high and sclk_o is low.
- R2: Command bits [4:0] hold the frame length minus one. A frame sends that many plus one bits: the low bits of the transmitted word, most significant of them first.
- R3: Writing 1 to command bit 30 launches a frame. Bit 30 reads 1 while the frame is pending or shifting and returns to 0 when it ends. A launch written while a frame is active is ignored.
- R4: Status bit 31 (busy) is 1 during a frame. Status bit 30 (ready) becomes 1 in the cycle busy drops. A launch clears ready, so busy and ready are never 1 together.
- R5: Ready (status bit 30), receive underrun (bit 27) and transmit overflow (bit 26) are sticky. Writing 1 to one of them clears it, writing 0 leaves it set, and writing back a value just read clears all events it held.
- R6: With command bit 12 set, cs_no is the inverse of command bit 13. With bit 12 clear, cs_no is low only while a frame shifts.
- R7: Command bit 15 enables transmit: when it is clear, mosi_o stays 0 and the transmit queue is not popped. Command bit 14 enables receive: when it is clear, nothing is pushed into the receive queue.
- R8: Command bit 26 is the clock polarity and sets the idle level of sclk_o. Command bit 18 is the clock phase: when clear, data is sampled on the leading edge; when set, on the trailing edge. Data changes on the opposite edge.
- R9: The received word is right-aligned. The first bit received sits at bit (length) and all bits above are 0.
- R10: Status flags: bit 25 receive queue empty, bit 24 receive queue full, bit 23 transmit queue empty, bit 22 transmit queue full. Both queues hold 4 words.
- R11: A write to a full transmit queue is dropped and sets transmit overflow. A read of an empty receive queue returns 0 and sets receive underrun.
- R12: One sclk_o period lasts CLK_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (pops the receive queue at 0x20) |
| bus_wdata_i | input | WORD_W | Write data |
| bus_rdata_o | output | WORD_W | Read data for the current address |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
The assertions assume the register port gives one strobe per cycle and that miso_i is stable around the sampling edge. They also assume CLK_DIV is even. The bench drives the bus only on falling clock edges, with exactly one strobe for each access. Its serial target model changes miso only after the edge on which the master samples. Before arming the model, the bench sets the mode with a separate write that has no launch bit, so an idle polarity change is never counted as a data edge.

// File: rtl/spi_word_pkg.sv
`timescale 1ns/1ps
package spi_word_pkg;
  localparam int REG_CMD  = 'h00;
  localparam int REG_STAT = 'h04;
  localparam int REG_TXQ  = 'h10;
  localparam int REG_RXQ  = 'h20;

  // command bit positions
  localparam int C_GO     = 30;
  localparam int C_CPOL   = 26;
  localparam int C_CPHA   = 18;
  localparam int C_TXEN   = 15;
  localparam int C_RXEN   = 14;
  localparam int C_CSVAL  = 13;
  localparam int C_CSSOFT = 12;

  // status bit positions
  localparam int S_BUSY   = 31;
  localparam int S_RDY    = 30;
  localparam int S_RXUNR  = 27;
  localparam int S_TXOVF  = 26;
  localparam int S_RXEMP  = 25;
  localparam int S_RXFUL  = 24;
  localparam int S_TXEMP  = 23;
  localparam int S_TXFUL  = 22;

  // stored command bits: fields [27:26], [19:18], [15:12], [4:0]
  localparam logic [31:0] CMD_KEEP = 32'h0C0C_F01F;

  typedef enum logic {SH_IDLE, SH_RUN} shift_state_e;
endpackage

// File: rtl/spi_word_fifo.sv
`timescale 1ns/1ps
module spi_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (cnt_q == $past(cnt_q)));
  assert_no_underrun_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);
endmodule

// File: rtl/spi_word_shifter.sv
`timescale 1ns/1ps
module spi_word_shifter
  import spi_word_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int CLK_DIV = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [$clog2(WORD_W)-1:0]  len_i,
  input  logic                       cpol_i,
  input  logic                       cpha_i,
  input  logic [WORD_W-1:0]          tx_word_i,
  input  logic                       miso_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [WORD_W-1:0]          rx_word_o,
  output logic                       sclk_o,
  output logic                       mosi_o
);
  localparam int LEN_W  = $clog2(WORD_W);
  localparam int EDGE_W = LEN_W + 1;
  localparam int HALF   = CLK_DIV / 2;
  localparam int DIV_W  = $clog2(HALF) + 1;

  shift_state_e      state_q;
  logic [DIV_W-1:0]  div_q;
  logic [EDGE_W-1:0] edge_q;
  logic [LEN_W-1:0]  len_q;
  logic              cpha_q, sclk_q, done_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q;
  logic              leading, do_sample, do_shift, last_edge;

  assign leading   = ~edge_q[0];
  assign do_sample = leading ^ cpha_q;
  // phase 1 presents the first bit before the first edge, so that edge must not shift
  assign do_shift  = !do_sample && !(cpha_q && edge_q == '0);
  assign last_edge = (edge_q == {len_q, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      div_q   <= '0;
      edge_q  <= '0;
      len_q   <= '0;
      cpha_q  <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q == SH_IDLE) begin
        sclk_q <= cpol_i;
        if (start_i) begin
          state_q <= SH_RUN;
          div_q   <= DIV_W'(HALF - 1);
          edge_q  <= '0;
          len_q   <= len_i;
          cpha_q  <= cpha_i;
          tx_sh_q <= tx_word_i << (LEN_W'(WORD_W - 1) - len_i);
          rx_sh_q <= '0;
        end
      end else if (div_q != '0) begin
        div_q <= div_q - 1'b1;
      end else begin
        div_q  <= DIV_W'(HALF - 1);
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (do_sample) rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_i};
        if (do_shift)  tx_sh_q <= tx_sh_q << 1;
        if (last_edge) begin
          state_q <= SH_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = (state_q == SH_RUN);
  assign done_o    = done_q;
  assign rx_word_o = rx_sh_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = tx_sh_q[WORD_W-1];

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idle_sclk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> (sclk_o == $past(cpol_i)));
  assert_rx_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && len_q != '1) |-> ((rx_sh_q >> ({1'b0, len_q} + 1'b1)) == '0));
endmodule

// File: rtl/spi_word_master.sv
`timescale 1ns/1ps
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 4,
  parameter int ADDR_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);
  localparam int LEN_W = $clog2(WORD_W);

  logic [WORD_W-1:0] cmd_q;
  logic go_pend_q, rdy_q, rx_unr_q, tx_ovf_q;
  logic wr_cmd, wr_stat, wr_tx, rd_rx;
  logic frame_active, launch;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [WORD_W-1:0] tx_head, rx_head, eng_tx, eng_rx;
  logic eng_busy, eng_done, tx_pop, rx_push, rx_pop;

  assign wr_cmd  = bus_we_i && (bus_addr_i == ADDR_W'(REG_CMD));
  assign wr_stat = bus_we_i && (bus_addr_i == ADDR_W'(REG_STAT));
  assign wr_tx   = bus_we_i && (bus_addr_i == ADDR_W'(REG_TXQ));
  assign rd_rx   = bus_re_i && (bus_addr_i == ADDR_W'(REG_RXQ));

  assign frame_active = go_pend_q | eng_busy | eng_done;
  assign launch       = wr_cmd && bus_wdata_i[C_GO] && !frame_active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      go_pend_q <= 1'b0;
      rdy_q     <= 1'b0;
      rx_unr_q  <= 1'b0;
      tx_ovf_q  <= 1'b0;
    end else begin
      if (wr_cmd) cmd_q <= bus_wdata_i & CMD_KEEP;
      go_pend_q <= launch;

      if (eng_done)                         rdy_q <= 1'b1;
      else if (launch)                      rdy_q <= 1'b0;
      else if (wr_stat && bus_wdata_i[S_RDY]) rdy_q <= 1'b0;

      if (rd_rx && rx_empty)                    rx_unr_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[S_RXUNR]) rx_unr_q <= 1'b0;

      if (wr_tx && tx_full)                     tx_ovf_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[S_TXOVF]) tx_ovf_q <= 1'b0;
    end
  end

  assign tx_pop  = go_pend_q && cmd_q[C_TXEN] && !tx_empty;
  assign eng_tx  = tx_pop ? tx_head : '0;
  assign rx_push = eng_done && cmd_q[C_RXEN];
  assign rx_pop  = rd_rx && !rx_empty;

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i(wr_tx), .wdata_i(bus_wdata_i), .pop_i(tx_pop),
    .rdata_o(tx_head), .empty_o(tx_empty), .full_o(tx_full)
  );

  spi_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(eng_rx), .pop_i(rx_pop),
    .rdata_o(rx_head), .empty_o(rx_empty), .full_o(rx_full)
  );

  spi_word_shifter #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk_i, .rst_ni,
    .start_i(go_pend_q),
    .len_i(cmd_q[LEN_W-1:0]),
    .cpol_i(cmd_q[C_CPOL]),
    .cpha_i(cmd_q[C_CPHA]),
    .tx_word_i(eng_tx),
    .miso_i,
    .busy_o(eng_busy),
    .done_o(eng_done),
    .rx_word_o(eng_rx),
    .sclk_o,
    .mosi_o
  );

  assign cs_no = cmd_q[C_CSSOFT] ? ~cmd_q[C_CSVAL] : ~eng_busy;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(REG_CMD)) begin
      bus_rdata_o       = cmd_q;
      bus_rdata_o[C_GO] = frame_active;
    end else if (bus_addr_i == ADDR_W'(REG_STAT)) begin
      bus_rdata_o[S_BUSY]  = frame_active;
      bus_rdata_o[S_RDY]   = rdy_q;
      bus_rdata_o[S_RXUNR] = rx_unr_q;
      bus_rdata_o[S_TXOVF] = tx_ovf_q;
      bus_rdata_o[S_RXEMP] = rx_empty;
      bus_rdata_o[S_RXFUL] = rx_full;
      bus_rdata_o[S_TXEMP] = tx_empty;
      bus_rdata_o[S_TXFUL] = tx_full;
    end else if (bus_addr_i == ADDR_W'(REG_RXQ)) begin
      bus_rdata_o = rx_empty ? '0 : rx_head;
    end
  end

  assert_bsy_rdy_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_active && rdy_q));
  assert_rdy_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q) |-> $past(eng_done));
  assert_go_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_busy && wr_cmd) |=> !go_pend_q);
  assert_ovf_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ovf_q) |-> $past(wr_tx && tx_full));
  assert_hw_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_q[C_CSSOFT] && $past(go_pend_q)) |-> !cs_no);
endmodule

// File: tb/tb_spi_word_master.sv
`timescale 1ns/1ps
module tb_spi_word_master;
  localparam int CLK_DIV = 4;
  localparam logic [7:0] A_CMD = 8'h00, A_STAT = 8'h04, A_TXQ = 8'h10, A_RXQ = 8'h20;
  localparam logic [31:0] GO = 32'h4000_0000;

  typedef struct packed {
    logic [1:0]  mode;   // {cpol, cpha}
    logic [4:0]  len;
    logic [31:0] tx;
    logic [31:0] sl;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 5'd7,  32'hDEAD_BEA5, 32'h0000_003C},
    '{2'd1, 5'd15, 32'h1234_C3A1, 32'hFFFF_5A0F},
    '{2'd2, 5'd31, 32'h8142_7EF0, 32'hA5C3_0F96},
    '{2'd3, 5'd23, 32'hFF96_0F3C, 32'h0012_3456},
    '{2'd0, 5'd0,  32'h0000_0001, 32'h0000_0001},
    '{2'd3, 5'd4,  32'h0000_0015, 32'h0000_000A}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi, miso, cs_n;

  int n_checks = 0, n_fail = 0;
  int cyc = 0;

  // serial target model
  logic armed = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0, s_prev = 1'b0;
  logic [31:0] s_word = '0, s_cap = '0;
  int s_n = 1, s_cnt = 0, s_last_rise = -1, s_period = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_word_master #(.CLK_DIV(CLK_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we), .bus_re_i(re),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  assign miso = (armed && s_cnt < s_n) ? s_word[s_n - 1 - s_cnt] : 1'b0;

  always @(sclk or armed) begin
    if (!armed) begin
      s_cnt = 0; s_cap = '0; s_last_rise = -1;
    end else if (sclk !== s_prev) begin
      if (sclk === 1'b1) begin
        if (s_last_rise >= 0) s_period = cyc - s_last_rise;
        s_last_rise = cyc;
      end
      if ((sclk === 1'b1) == (m_cpol == m_cpha)) begin
        s_cap = {s_cap[30:0], mosi};
        s_cnt = s_cnt + 1;
      end
    end
    s_prev = sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  function automatic logic [31:0] mask_of(input logic [4:0] len);
    return (len == 5'd31) ? 32'hFFFF_FFFF : ((32'd1 << (len + 1)) - 1);
  endfunction

  function automatic logic [31:0] cmd_of(input logic [1:0] mode, input logic [4:0] len,
                                         input logic en_tx, input logic en_rx);
    return {27'd0, len} | (32'(en_rx) << 14) | (32'(en_tx) << 15) |
           (32'(mode[0]) << 18) | (32'(mode[1]) << 26);
  endfunction

  task automatic wait_done(input string req);
    logic [31:0] st = '0;
    for (int i = 0; i < 1000; i++) begin
      bus_read(A_STAT, st);
      if (st[30]) break;
    end
    chk(req, {31'd0, st[30]}, 32'd1);
  endtask

  // leaves the model armed so the caller can inspect what it captured
  task automatic do_frame(input logic [1:0] mode, input logic [4:0] len, input logic [31:0] tx,
                          input logic [31:0] sl, input logic push, input logic en_tx,
                          input logic en_rx);
    logic [31:0] c;
    c = cmd_of(mode, len, en_tx, en_rx);
    armed = 1'b0;
    m_cpol = mode[1]; m_cpha = mode[0]; s_word = sl; s_n = int'(len) + 1;
    if (push) bus_write(A_TXQ, tx);
    bus_write(A_CMD, c);
    repeat (3) @(negedge clk);
    armed = 1'b1;
    bus_write(A_CMD, c | GO);
    wait_done("R4 ready after frame");
  endtask

  initial begin
    logic [31:0] d, st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_CMD, d);  chk("R1 command", d, 32'h0);
    bus_read(A_STAT, d); chk("R1 status", d, 32'h0280_0000);
    chk("R1 cs_no", {31'd0, cs_n}, 32'd1);
    chk("R1 sclk", {31'd0, sclk}, 32'd0);

    // R2 R8 R9 R12: table of frames across modes and lengths
    foreach (VECS[i]) begin
      do_frame(VECS[i].mode, VECS[i].len, VECS[i].tx, VECS[i].sl, 1'b1, 1'b1, 1'b1);
      chk("R2 bit count", s_cnt, int'(VECS[i].len) + 1);
      chk("R2 R8 mosi bits", s_cap, VECS[i].tx & mask_of(VECS[i].len));
      if (VECS[i].len == 5'd31) chk("R12 sclk period", s_period, CLK_DIV);
      armed = 1'b0;
      bus_read(A_RXQ, d);
      chk("R9 R8 rx word", d, VECS[i].sl & mask_of(VECS[i].len));
      bus_read(A_STAT, st);
      bus_write(A_STAT, st);
      bus_read(A_STAT, d);
      chk("R5 writeback clears ready", d & 32'hCC00_0000, 32'h0);
    end

    // R3 R4 R6: readback while active, launch ignored while busy
    do_frame(2'd0, 5'd7, 32'h11, 32'h0, 1'b1, 1'b1, 1'b1);   // leaves ready set
    armed = 1'b0;
    bus_read(A_RXQ, d);
    bus_write(A_TXQ, 32'h0000_00C3);
    bus_write(A_TXQ, 32'h0000_0096);
    bus_write(A_CMD, cmd_of(2'd0, 5'd7, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    armed = 1'b1;
    bus_write(A_CMD, cmd_of(2'd0, 5'd7, 1'b1, 1'b1) | GO);
    bus_read(A_CMD, d);  chk("R3 go reads one while active", {31'd0, d[30]}, 32'd1);
    bus_read(A_STAT, d); chk("R4 busy set ready cleared", d[31:30], 2'b10);
    chk("R6 hardware cs low in frame", {31'd0, cs_n}, 32'd0);
    bus_write(A_CMD, cmd_of(2'd0, 5'd7, 1'b1, 1'b1) | GO);
    wait_done("R4 ready after frame");
    repeat (CLK_DIV * 20) @(negedge clk);
    chk("R3 second launch ignored", s_cnt, 8);
    chk("R2 first queued word sent", s_cap, 32'hC3);
    bus_read(A_CMD, d);  chk("R3 go clears at end", {31'd0, d[30]}, 32'd0);
    bus_read(A_STAT, d); chk("R3 tx word still queued", {31'd0, d[23]}, 32'd0);
    chk("R6 hardware cs high after", {31'd0, cs_n}, 32'd1);
    do_frame(2'd0, 5'd7, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1);
    chk("R2 second queued word sent", s_cap, 32'h96);
    armed = 1'b0;
    bus_read(A_RXQ, d);
    bus_read(A_RXQ, d);

    // R5 R10 R11: sticky events
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); chk("R5 zero write keeps ready", {31'd0, d[30]}, 32'd1);
    bus_read(A_RXQ, d);  chk("R11 empty read returns zero", d, 32'h0);
    bus_read(A_STAT, d); chk("R11 underrun set", {31'd0, d[27]}, 32'd1);
    for (int k = 0; k < 5; k++) bus_write(A_TXQ, 32'hA0 + k);
    bus_read(A_STAT, st);
    chk("R11 overflow set", {31'd0, st[26]}, 32'd1);
    chk("R10 tx full flag", {31'd0, st[22]}, 32'd1);
    bus_write(A_STAT, st);
    bus_read(A_STAT, d);
    chk("R5 writeback clears events", d & 32'h4C00_0000, 32'h0);
    chk("R10 tx full unaffected", {31'd0, d[22]}, 32'd1);

    // R7 receive disabled while draining; R11 fifth word was dropped
    for (int k = 0; k < 4; k++) begin
      do_frame(2'd1, 5'd7, 32'h0, 32'h55, 1'b0, 1'b1, 1'b0);
      if (k == 3) chk("R11 dropped word never sent", s_cap, 32'hA3);
      armed = 1'b0;
    end
    bus_read(A_STAT, d);
    chk("R7 rx disabled leaves rx empty", {31'd0, d[25]}, 32'd1);
    chk("R10 tx drained", {31'd0, d[23]}, 32'd1);

    // R7 transmit disabled
    bus_write(A_TXQ, 32'hFF);
    do_frame(2'd0, 5'd7, 32'h0, 32'h5A, 1'b0, 1'b0, 1'b1);
    chk("R7 mosi low without txen", s_cap, 32'h0);
    armed = 1'b0;
    bus_read(A_STAT, d); chk("R7 tx queue not popped", {31'd0, d[23]}, 32'd0);
    bus_read(A_RXQ, d);  chk("R7 rx still received", d, 32'h5A);

    // R10 receive queue full
    for (int k = 0; k < 4; k++) begin
      do_frame(2'd2, 5'd7, 32'h0, 32'h10 + k, 1'b0, 1'b0, 1'b1);
      armed = 1'b0;
    end
    bus_read(A_STAT, d); chk("R10 rx full and not empty", d[25:24], 2'b01);
    for (int k = 0; k < 4; k++) begin
      bus_read(A_RXQ, d); chk("R10 rx order", d, 32'h10 + k);
    end

    // R6 software chip select
    bus_write(A_CMD, 32'h0000_3000);
    @(negedge clk); chk("R6 soft cs asserted", {31'd0, cs_n}, 32'd0);
    bus_write(A_CMD, 32'h0000_1000);
    @(negedge clk); chk("R6 soft cs released", {31'd0, cs_n}, 32'd1);

    // R8 idle polarity
    bus_write(A_CMD, 32'h0400_0000);
    repeat (2) @(negedge clk);
    chk("R8 idle sclk follows polarity", {31'd0, sclk}, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule